// File: doc/BRIEF.md
# Serial ADC Scan Sequencer

This block runs a multi-channel scan on an external serial successive-approximation converter. The converter has one quirk: the word it shifts back during a command transfer is the result of the conversion that the previous command started. A trigger latches an enable mask and a per-channel differential mask. The sequencer then visits every enabled channel, lowest index first. For each channel it builds a command byte and shifts it out in a 16-clock framed SPI transfer, mode 0, while it captures the returning word. It then waits for the converter's end-of-conversion line to rise.

The word captured during the first command of a scan is stale and is dropped. After the last channel, one status-read command is sent only to pull out the final result. Every kept word is turned into a sign-extended sample and tagged with the channel it belongs to. A one-cycle done flag closes the scan. An error flag is raised together with done when end-of-conversion does not arrive in time.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, cs_n is 1, sclk is 0, and busy, smp_valid, scan_done and scan_err are all 0.
- R2: A scan sends one conversion command for each enabled channel in ascending channel order, and then exactly one status command. In the full-width variant the status command is 8'h0C.
- R3: A conversion command has bit 7 set to 1 when the channel's ch_diff bit is 0 (single-ended) and to 0 when it is 1 (differential). Bits 6:4 hold the multiplexer code, and channels 0..7 use codes 0,4,1,5,2,6,3,7. Bits 3:0 are zero.
- R4: The word captured during the first command of a scan produces no sample. Every later captured word is output as the sample of the channel whose command was sent in the transfer before it, so a scan gives exactly one sample per enabled channel, in ascending order.
- R5: A sample is bits 15:3 of the captured word (MSB received first), sign-extended from bit 12 to the output width. Bits 2:0 have no effect.
- R6: Each transfer holds cs_n low for exactly 16 rising edges of sclk. sclk rests at 0 whenever cs_n is high. mosi carries the command byte and then 8 zero bits, MSB first, changing after falling edges. miso is sampled at rising edges.
- R7: After each conversion command, no further transfer starts until a rising edge has been seen on eoc.
- R8: If no eoc rising edge arrives within EOC_TIMEOUT clock cycles after a conversion transfer, the scan stops with scan_err and scan_done high in the same cycle, and no further transfer takes place.
- R9: A trigger with an all-zero enable mask raises scan_done in the following cycle, with no transfer and no sample.
- R10: A trigger that arrives while busy is high is ignored. It starts no second scan and does not change the channel list.
- R11: With SMALL_VARIANT set, every command byte is reshaped: bits 7:6 are kept, bits 3:0 move to bits 5:2, and bits 1:0 become zero. The status command therefore becomes 8'h30.
- R12: The last sample of a scan that completes normally is valid in the same cycle as scan_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Scan trigger, sampled while idle |
| ch_en | input | NUM_CH | Channel enable mask, latched at the trigger |
| ch_diff | input | NUM_CH | 1 selects differential input for that channel |
| eoc | input | 1 | End-of-conversion from the converter, rising edge meaningful |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low transfer frame |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | A scan is in progress |
| smp_valid | output | 1 | One-cycle strobe for smp_ch and smp_data |
| smp_ch | output | $clog2(NUM_CH) | Channel index of the sample |
| smp_data | output | OUT_W | Sign-extended sample |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| scan_err | output | 1 | One-cycle pulse, end-of-conversion timeout |

## Verification
The final status transfer does two things in one cycle: it delivers the last channel's sample and it ends the scan. Every normal scan is therefore judged on whether smp_valid and scan_done rise together, and on whether the expected-sample queue is empty at that point. A retrigger sent part-way through a scan, with a different mask, provokes the second overlap: a new trigger against a running scan. It is judged by the command log and the done count, which must be unchanged.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_SHIFT,
    ST_WAIT,
    ST_DRAIN,
    ST_DSHIFT
  } seq_st_e;

  localparam logic [7:0] STATUS_CMD = 8'h0C;

  // Interleaved map: code = {ch[0], ch[2:1]}
  function automatic logic [2:0] mux_code(input logic [2:0] ch);
    return {ch[0], ch[2:1]};
  endfunction

endpackage

// File: rtl/adc_spi_xfer.sv
`timescale 1ns/1ps
module adc_spi_xfer #(
  parameter int WORD_W   = 16,
  parameter int KEEP_W   = 13,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [KEEP_W-1:0] rx_hi
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);

  logic              active;
  logic [DIV_W-1:0]  div;
  logic [BIT_W-1:0]  bitn;
  logic [WORD_W-1:0] txs;
  logic [WORD_W-1:0] rxs;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      div    <= '0;
      bitn   <= '0;
      txs    <= '0;
      rxs    <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          mosi   <= tx[WORD_W-1];
          txs    <= {tx[WORD_W-2:0], 1'b0};
          div    <= '0;
          bitn   <= '0;
        end
      end else if (div == DIV_W'(HALF_DIV - 1)) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rxs  <= {rxs[WORD_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == BIT_W'(WORD_W - 1)) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            mosi <= txs[WORD_W-1];
            txs  <= {txs[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  assign rx_hi = rxs[WORD_W-1 -: KEEP_W];

endmodule

// File: rtl/adc_cmd_build.sv
`timescale 1ns/1ps
module adc_cmd_build #(
  parameter bit SMALL_VARIANT = 1'b0
) (
  input  logic [2:0] ch,
  input  logic       diff,
  input  logic       status,
  output logic [7:0] cmd
);
  import adc_seq_pkg::*;

  logic [7:0] raw;
  assign raw = status ? STATUS_CMD : {~diff, mux_code(ch), 4'b0000};

  generate
    if (SMALL_VARIANT) begin : g_small
      assign cmd = (raw & 8'hC0) | ((raw & 8'h0F) << 2);
    end else begin : g_full
      assign cmd = raw;
    end
  endgenerate

endmodule

// File: rtl/adc_low_pick.sv
`timescale 1ns/1ps
module adc_low_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  output logic              any,
  output logic [CH_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) idx = CH_W'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq #(
  parameter int NUM_CH        = 8,
  parameter int WORD_W        = 16,
  parameter int RES_W         = 13,
  parameter int OUT_W         = 16,
  parameter int HALF_DIV      = 2,
  parameter int EOC_TIMEOUT   = 4000,
  parameter bit SMALL_VARIANT = 1'b0,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_start,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_diff,
  input  logic              eoc,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              smp_valid,
  output logic [CH_W-1:0]   smp_ch,
  output logic [OUT_W-1:0]  smp_data,
  output logic              scan_done,
  output logic              scan_err
);
  import adc_seq_pkg::*;

  localparam int TMR_W = $clog2(EOC_TIMEOUT + 1);

  seq_st_e           state;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] diff_l;
  logic [CH_W-1:0]   cur_ch;
  logic [CH_W-1:0]   prev_ch;
  logic              first;
  logic [TMR_W-1:0]  timer;
  logic [2:0]        eoc_s;
  logic              eoc_rise;

  logic              pick_any;
  logic [CH_W-1:0]   pick_idx;
  logic [7:0]        cmd;
  logic              xfer_start;
  logic              xfer_done;
  logic [RES_W-1:0]  xfer_rx;

  adc_low_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask (state == ST_IDLE ? ch_en : pend),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  adc_cmd_build #(.SMALL_VARIANT(SMALL_VARIANT)) u_cmd (
    .ch     (3'(cur_ch)),
    .diff   (diff_l[cur_ch]),
    .status (state == ST_DRAIN),
    .cmd    (cmd)
  );

  assign xfer_start = (state == ST_LAUNCH) || (state == ST_DRAIN);

  adc_spi_xfer #(.WORD_W(WORD_W), .KEEP_W(RES_W), .HALF_DIV(HALF_DIV)) u_spi (
    .clk   (clk),
    .rst   (rst),
    .start (xfer_start),
    .tx    ({cmd, (WORD_W - 8)'(0)}),
    .miso  (miso),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .mosi  (mosi),
    .done  (xfer_done),
    .rx_hi (xfer_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) eoc_s <= '0;
    else     eoc_s <= {eoc_s[1:0], eoc};
  end
  assign eoc_rise = eoc_s[1] & ~eoc_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= '0;
      diff_l    <= '0;
      cur_ch    <= '0;
      prev_ch   <= '0;
      first     <= 1'b0;
      timer     <= '0;
      smp_valid <= 1'b0;
      smp_ch    <= '0;
      smp_data  <= '0;
      scan_done <= 1'b0;
      scan_err  <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      scan_done <= 1'b0;
      scan_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (scan_start) begin
            if (!pick_any) begin
              scan_done <= 1'b1;
            end else begin
              pend   <= ch_en;
              diff_l <= ch_diff;
              cur_ch <= pick_idx;
              first  <= 1'b1;
              state  <= ST_LAUNCH;
            end
          end
        end
        ST_LAUNCH: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (xfer_done) begin
            if (!first) begin
              smp_valid <= 1'b1;
              smp_ch    <= prev_ch;
              smp_data  <= {{(OUT_W-RES_W){xfer_rx[RES_W-1]}}, xfer_rx};
            end
            first        <= 1'b0;
            prev_ch      <= cur_ch;
            pend[cur_ch] <= 1'b0;
            timer        <= '0;
            state        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (eoc_rise) begin
            if (pick_any) begin
              cur_ch <= pick_idx;
              state  <= ST_LAUNCH;
            end else begin
              state  <= ST_DRAIN;
            end
          end else if (timer == TMR_W'(EOC_TIMEOUT - 1)) begin
            scan_err  <= 1'b1;
            scan_done <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_DRAIN: state <= ST_DSHIFT;
        ST_DSHIFT: begin
          if (xfer_done) begin
            smp_valid <= 1'b1;
            smp_ch    <= prev_ch;
            smp_data  <= {{(OUT_W-RES_W){xfer_rx[RES_W-1]}}, xfer_rx};
            scan_done <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/adc_scan_seq_chk.sv
`timescale 1ns/1ps
module adc_scan_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic smp_valid,
  input logic scan_done,
  input logic scan_err
);
  localparam int CNT_W = $clog2(WORD_W + 1) + 1;

  logic             sclk_q;
  logic [CNT_W-1:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n)                rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R6: exactly WORD_W rising edges per frame
  a_r6_frame_len: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> rise_cnt == CNT_W'(WORD_W));

  // R6: clock idles low outside a frame
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R6: frames only inside a scan
  a_r6_frame_in_scan: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R8: error always ends the scan
  a_r8_err_ends_scan: assert property (@(posedge clk) disable iff (rst)
    scan_err |-> scan_done);

  // R4: samples only come out of a running scan
  a_r4_sample_from_scan: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(busy));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .busy      (busy),
  .smp_valid (smp_valid),
  .scan_done (scan_done),
  .scan_err  (scan_err)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module adc_conv_model #(
  parameter logic [7:0] STATUS_CODE = 8'h0C
) (
  input  logic clk,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic eoc_en,
  output logic miso,
  output logic eoc
);
  logic [15:0] last_word = 16'h1357;
  logic [15:0] cur_word  = 16'h0000;
  logic [7:0]  cmd_sh    = 8'h00;
  int          nbits     = 0;
  int          dly       = 0;
  bit          pend_conv = 0;
  int          viol      = 0;
  logic [7:0]  cmds[$];
  int          edge_cnts[$];

  function automatic logic [12:0] resv(input logic [7:0] c);
    return {c, c[7:4] ^ 4'hA, 1'b1};
  endfunction

  initial begin
    miso = 1'b0;
    eoc  = 1'b0;
  end

  always @(negedge cs_n) begin
    eoc = 1'b0;
    if (pend_conv) viol++;
    cur_word = last_word;
    miso     = cur_word[15];
    cur_word = {cur_word[14:0], 1'b0};
    nbits    = 0;
    cmd_sh   = 8'h00;
  end

  always @(posedge sclk) if (!cs_n) begin
    if (nbits < 8) cmd_sh = {cmd_sh[6:0], mosi};
    nbits++;
  end

  always @(negedge sclk) if (!cs_n) begin
    miso     = cur_word[15];
    cur_word = {cur_word[14:0], 1'b0};
  end

  always @(posedge cs_n) if (nbits > 0) begin
    cmds.push_back(cmd_sh);
    edge_cnts.push_back(nbits);
    if (cmd_sh != STATUS_CODE) begin
      last_word = {resv(cmd_sh), 3'b110};
      if (eoc_en) begin
        pend_conv = 1;
        dly       = 20;
      end
    end
  end

  always @(negedge clk) if (dly > 0) begin
    dly = dly - 1;
    if (dly == 0) begin
      eoc       = 1'b1;
      pend_conv = 0;
    end
  end
endmodule

module sim_adc_scan_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_start = 1'b0;
  logic [7:0] ch_en = 8'h00;
  logic [7:0] ch_diff = 8'h00;
  logic       eoc_en0 = 1'b1;

  logic       cs_n0, sclk0, mosi0, miso0, eoc0;
  logic       busy0, valid0, done0, err0;
  logic [2:0] ch0;
  logic [15:0] data0;
  logic       cs_n1, sclk1, mosi1, miso1, eoc1;
  logic       busy1, valid1, done1, err1;
  logic [2:0] ch1;
  logic [15:0] data1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int done_cnt = 0, u1_done_cnt = 0;
  bit last_err = 0, last_done_valid = 0;
  int exp_ch[$];
  logic [15:0] exp_dat[$];
  int u1_ch[$];
  logic [15:0] u1_dat[$];

  always #2.5 clk = ~clk;

  adc_scan_seq #(.EOC_TIMEOUT(200)) u0 (
    .clk(clk), .rst(rst), .scan_start(scan_start), .ch_en(ch_en), .ch_diff(ch_diff),
    .eoc(eoc0), .miso(miso0), .cs_n(cs_n0), .sclk(sclk0), .mosi(mosi0), .busy(busy0),
    .smp_valid(valid0), .smp_ch(ch0), .smp_data(data0), .scan_done(done0), .scan_err(err0));

  adc_conv_model #(.STATUS_CODE(8'h0C)) m0 (
    .clk(clk), .cs_n(cs_n0), .sclk(sclk0), .mosi(mosi0), .eoc_en(eoc_en0), .miso(miso0), .eoc(eoc0));

  adc_scan_seq #(.EOC_TIMEOUT(200), .SMALL_VARIANT(1'b1)) u1 (
    .clk(clk), .rst(rst), .scan_start(scan_start), .ch_en(ch_en), .ch_diff(ch_diff),
    .eoc(eoc1), .miso(miso1), .cs_n(cs_n1), .sclk(sclk1), .mosi(mosi1), .busy(busy1),
    .smp_valid(valid1), .smp_ch(ch1), .smp_data(data1), .scan_done(done1), .scan_err(err1));

  adc_conv_model #(.STATUS_CODE(8'h30)) m1 (
    .clk(clk), .cs_n(cs_n1), .sclk(sclk1), .mosi(mosi1), .eoc_en(1'b1), .miso(miso1), .eoc(eoc1));

  function automatic logic [2:0] map_ch(input int c);
    case (c)
      0: return 3'd0; 1: return 3'd4; 2: return 3'd1; 3: return 3'd5;
      4: return 3'd2; 5: return 3'd6; 6: return 3'd3; default: return 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] exp_sample(input logic [7:0] c);
    logic [12:0] v;
    v = {c, c[7:4] ^ 4'hA, 1'b1};
    return {{3{v[12]}}, v};
  endfunction

  function automatic logic [7:0] conv_cmd(input int c, input logic d);
    return {~d, map_ch(c), 4'b0000};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the expected sample stream
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (valid0) begin
        if (exp_ch.size() == 0) begin
          check(0, "R4", "unexpected sample", int'(ch0), -1);
        end else begin
          int ec;
          logic [15:0] ed;
          ec = exp_ch.pop_front();
          ed = exp_dat.pop_front();
          check(int'(ch0) == ec, "R4", "sample channel", int'(ch0), ec);
          check(data0 == ed, "R5", "sample value", int'(data0), int'(ed));
        end
      end
      if (done0) begin
        done_cnt++;
        last_err = err0;
        last_done_valid = valid0;
      end
      if (valid1) begin
        u1_ch.push_back(int'(ch1));
        u1_dat.push_back(data1);
      end
      if (done1) u1_done_cnt++;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_both_done();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done_cnt > 0 && u1_done_cnt > 0) break;
    end
    check(done_cnt > 0, "R2", "scan_done seen", done_cnt, 1);
  endtask

  task automatic pulse_start();
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
  endtask

  task automatic clear_logs();
    m0.cmds.delete(); m0.edge_cnts.delete();
    m1.cmds.delete(); m1.edge_cnts.delete();
    u1_ch.delete(); u1_dat.delete();
    done_cnt = 0; u1_done_cnt = 0;
  endtask

  task automatic run_scan(input logic [7:0] mask, input logic [7:0] dmask, input bit inject);
    logic [7:0] ecmd[$];
    while (busy0 || busy1) @(negedge clk);
    clear_logs();
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        ecmd.push_back(conv_cmd(c, dmask[c]));
        exp_ch.push_back(c);
        exp_dat.push_back(exp_sample(conv_cmd(c, dmask[c])));
      end
    end
    ecmd.push_back(8'h0C);
    ch_en = mask; ch_diff = dmask;
    pulse_start();
    if (inject) begin
      repeat (30) @(negedge clk);
      ch_en = 8'hF0;            // R10: retrigger while busy, other mask
      pulse_start();
    end
    wait_both_done();
    repeat (100) @(negedge clk);
    check(exp_ch.size() == 0, "R4", "samples left over", exp_ch.size(), 0);
    check(m0.cmds.size() == ecmd.size(), "R2", "transfer count", m0.cmds.size(), ecmd.size());
    for (int i = 0; i < ecmd.size() && i < m0.cmds.size(); i++)
      check(m0.cmds[i] == ecmd[i], "R3", "command byte", int'(m0.cmds[i]), int'(ecmd[i]));
    foreach (m0.edge_cnts[i])
      check(m0.edge_cnts[i] == 16, "R6", "sclk edges per frame", m0.edge_cnts[i], 16);
    check(m0.viol == 0, "R7", "transfer before eoc", m0.viol, 0);
    check(last_err == 0, "R8", "unexpected error", int'(last_err), 0);
    check(last_done_valid == 1, "R12", "last sample with done", int'(last_done_valid), 1);
    if (inject) check(done_cnt == 1, "R10", "scans completed", done_cnt, 1);
    exp_ch.delete(); exp_dat.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values while held
    check(cs_n0 == 1 && sclk0 == 0, "R1", "cs_n/sclk in reset", {cs_n0, sclk0}, 2);
    rst = 1'b0;
    @(negedge clk);
    check({busy0, valid0, done0, err0} == 4'b0, "R1", "flags after reset",
          {busy0, valid0, done0, err0}, 0);
    check(cs_n0 == 1, "R1", "cs_n after reset", cs_n0, 1);

    // R2 R3 R4 R5 R12: full mask, all single-ended (negative samples)
    run_scan(8'hFF, 8'h00, 0);
    // mixed mask and modes (positive and negative samples)
    run_scan(8'hA5, 8'h0F, 0);
    // single channel: only the drain yields its sample
    run_scan(8'h80, 8'h80, 0);
    // R10: trigger while busy ignored
    run_scan(8'h03, 8'h01, 1);

    // R9: empty mask
    while (busy0 || busy1) @(negedge clk);
    clear_logs();
    ch_en = 8'h00;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    check(done0 == 1 && valid0 == 0, "R9", "done next cycle", {done0, valid0}, 2);
    repeat (50) @(negedge clk);
    check(m0.cmds.size() == 0 && busy0 == 0, "R9", "no traffic", m0.cmds.size(), 0);

    // R8: timeout
    clear_logs();
    eoc_en0 = 1'b0;
    ch_en = 8'h06; ch_diff = 8'h00;
    pulse_start();
    wait_both_done();
    check(last_err == 1, "R8", "scan_err with done", int'(last_err), 1);
    repeat (100) @(negedge clk);
    check(m0.cmds.size() == 1, "R8", "transfers after timeout", m0.cmds.size(), 1);
    if (m0.cmds.size() > 0)
      check(m0.cmds[0] == conv_cmd(1, 1'b0), "R8", "only first command", int'(m0.cmds[0]),
            int'(conv_cmd(1, 1'b0)));
    check(exp_ch.size() == 0, "R4", "no sample on abort", exp_ch.size(), 0);
    eoc_en0 = 1'b1;

    // R11: small variant remap on u1
    while (busy0 || busy1) @(negedge clk);
    run_scan(8'h03, 8'h02, 0);
    check(m1.cmds.size() == 3, "R11", "small transfer count", m1.cmds.size(), 3);
    if (m1.cmds.size() == 3) begin
      check(m1.cmds[0] == 8'h80, "R11", "small cmd ch0", int'(m1.cmds[0]), 8'h80);
      check(m1.cmds[1] == 8'h40, "R11", "small cmd ch1", int'(m1.cmds[1]), 8'h40);
      check(m1.cmds[2] == 8'h30, "R11", "small status", int'(m1.cmds[2]), 8'h30);
    end
    check(u1_ch.size() == 2, "R11", "small sample count", u1_ch.size(), 2);
    if (u1_ch.size() == 2) begin
      check(u1_dat[0] == exp_sample(8'h80), "R11", "small sample ch0", int'(u1_dat[0]),
            int'(exp_sample(8'h80)));
      check(u1_dat[1] == exp_sample(8'h40), "R11", "small sample ch1", int'(u1_dat[1]),
            int'(exp_sample(8'h40)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule